// File: doc/BRIEF.md
# Parallel Transmit Data Unpacker

The block takes a stream of bytes through a valid/ready handshake and drives them onto a parallel output bus. Software picks the bus width at run time from a 3-bit selector: 16, 8, 4, 2 or 1 bits. For the narrow widths, each byte is cut into slices. The slices go out either most-significant first or least-significant first. In 16-bit mode, two bytes form one bus word. A `go` pulse launches a transfer of `cfg_len` bytes. A one-cycle `done` pulse closes the transfer.

Besides the data, the block drives an optional word strobe and a clock-enable for the output clock. When gating is on, the clock-enable stops the clock on cycles without new data. The block also drives a launch-edge select for the pad clock. The `flush` input clears all local state and returns the block to idle.

The controller has four states:
- **IDLE** waits for `go`.
- **FETCH** asserts `in_ready` and takes one byte per cycle.
- **SEND** emits the remaining slices of the held byte.
- **DONE** lasts one cycle and raises `done`.

The state transitions are:
- IDLE→FETCH on `go` with a legal code and a non-zero length.
- IDLE→DONE on `go` with a length of zero.
- FETCH→SEND when an accepted byte has more slices to emit.
- FETCH→FETCH after an accepted byte, while bytes remain.
- FETCH→DONE on the last byte in the 8-bit and 16-bit modes.
- SEND→FETCH after the last slice, while bytes remain.
- SEND→DONE after the last slice of the last byte.
- DONE→IDLE always.
- `flush` forces any state to IDLE.

Top module: `ptx_unpack`

## Requirements
- R1: After reset, `bus_data` is 0 and `bus_valid`, `done`, `in_ready` and `out_clk_inv` are all 0.
- R2: The width codes are 0 for 16 bits, 1 for 8, 2 for 4, 3 for 2 and 4 for 1. Codes 5 to 7 are reserved. A `go` with a reserved code is ignored: `in_ready` and `done` stay 0.
- R3: In 8-bit mode, each accepted byte appears as one word on `bus_data[7:0]`, with `bus_data[15:8]` at 0. The word appears in the cycle after the byte is accepted.
- R4: In 4-, 2- and 1-bit modes with `cfg_lsb_first`=0, a byte gives 8/w words in consecutive cycles. The most significant slice comes first. Each slice sits in `bus_data[w-1:0]` and all other bits are 0.
- R5: With `cfg_lsb_first`=1, the slices of each byte come out least significant first.
- R6: In 16-bit mode, the first byte of each pair goes to `bus_data[7:0]` and the second to `bus_data[15:8]`. If the byte count is odd, the last word carries zeros in `bus_data[15:8]`.
- R7: `done` is high for exactly one cycle, in the same cycle as the final word. In the next cycle, `done`, `bus_valid` and `in_ready` are all 0.
- R8: A `go` with `cfg_len`=0 raises `done` in the following cycle and emits no word.
- R9: A `go` during an active transfer is ignored. The transfer keeps its length and its settings.
- R10: If no byte is offered while `in_ready` is 1, the next cycle shows `bus_valid`=0 and an unchanged `bus_data`.
- R11: The width, the slice order, the strobe enable and the edge select are captured at `go`. With the strobe disabled, `bus_valid` stays 0 while data still moves.
- R12: When `cfg_gate_en` is 0, `out_clk_en` is always 1. When it is 1, `out_clk_en` is 1 exactly in the cycles where a new word is on the bus.
- R13: `out_clk_inv` equals the `cfg_fall_edge` value captured at the last accepted `go`. Later changes to `cfg_fall_edge` do not affect it.
- R14: `flush` returns the block to idle. In the next cycle, `bus_data` is 0, and `bus_valid`, `in_ready` and `done` are 0. No `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all local state |
| go | input | 1 | Start pulse for one transfer |
| cfg_width_sel | input | 3 | Bus width code |
| cfg_len | input | LEN_W | Byte count of the transfer |
| cfg_lsb_first | input | 1 | Slice order: 0 = MSB first, 1 = LSB first |
| cfg_fall_edge | input | 1 | Launch edge: 0 = rising, 1 = falling |
| cfg_strobe_en | input | 1 | Enables the `bus_valid` strobe |
| cfg_gate_en | input | 1 | Enables idle clock gating |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| bus_data | output | 16 | Parallel output word |
| bus_valid | output | 1 | Marks a cycle carrying a new word |
| done | output | 1 | One-cycle end-of-transfer pulse |
| out_clk_en | output | 1 | Enable for the output clock |
| out_clk_inv | output | 1 | Launch on the falling edge when 1 |

## Verification
Each fault in the internal state shows at the ports within one transfer:
- A slice index that advances wrongly reorders or drops words in the collected stream. The stream is checked against an arithmetic model at the `done` cycle.
- A byte counter that is off by one makes `done` come one word early or late. It can also leave `in_ready` high after `done`, which is checked in the very next cycle.
- A stall that is handled wrongly shows up one cycle later, as a spurious strobe or a changed bus word.
- A configuration latch that is not held shows up at the end of the transfer, as a wrong edge select or a wrong slice order.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    localparam int BYTE_W = 8;
    localparam int BUS_W  = 2 * BYTE_W;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_DONE
    } ptx_state_e;

    localparam logic [2:0] WSEL_16 = 3'd0;
    localparam logic [2:0] WSEL_8  = 3'd1;
    localparam logic [2:0] WSEL_4  = 3'd2;
    localparam logic [2:0] WSEL_2  = 3'd3;
    localparam logic [2:0] WSEL_1  = 3'd4;

    function automatic logic code_ok(input logic [2:0] c);
        return c <= WSEL_1;
    endfunction

    // bits carried by one slice of a byte
    function automatic logic [3:0] slice_bits(input logic [2:0] c);
        logic [3:0] r;
        unique case (c)
            WSEL_4:  r = 4'd4;
            WSEL_2:  r = 4'd2;
            WSEL_1:  r = 4'd1;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

    // number of bus words one byte produces (16-bit mode handled apart)
    function automatic logic [3:0] slices_per_byte(input logic [2:0] c);
        logic [3:0] r;
        unique case (c)
            WSEL_4:  r = 4'd2;
            WSEL_2:  r = 4'd4;
            WSEL_1:  r = 4'd8;
            default: r = 4'd1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ptx_slicer.sv
module ptx_slicer
    import ptx_pkg::*;
(
    input  logic [BYTE_W-1:0] bin_i,
    input  logic [2:0]        mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              lsb_first_i,
    output logic [BUS_W-1:0]  slice_o
);
    logic [3:0]        w;
    logic [3:0]        idx4;
    logic [3:0]        prod;
    logic [3:0]        sh;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        w       = slice_bits(mode_i);
        idx4    = {1'b0, idx_i};
        prod    = w * idx4;
        sh      = lsb_first_i ? prod : (4'd8 - w - prod);
        mask    = 8'hFF >> (4'd8 - w);
        shifted = bin_i >> sh;
        slice_o = {{(BUS_W-BYTE_W){1'b0}}, shifted & mask};
    end
endmodule

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
    import ptx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              go_i,
    input  logic [2:0]        width_sel_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              lsb_first_i,
    input  logic              fall_edge_i,
    input  logic              strobe_en_i,
    input  logic              gate_en_i,
    input  logic [BYTE_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic [BUS_W-1:0]  bus_data_o,
    output logic              bus_valid_o,
    output logic              done_o,
    output logic              clk_en_o,
    output logic              clk_inv_o
);
    ptx_state_e        state_q, state_d;
    logic [LEN_W-1:0]  left_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] low_q;
    logic [BUS_W-1:0]  data_q;
    logic              word_q;
    logic [2:0]        mode_q;
    logic              lsb_q;
    logic              strobe_q;
    logic              edge_q;

    logic [3:0]        nslc;
    logic              mode16;
    logic              last_slice;
    logic              start_ok;
    logic              take;
    logic [BYTE_W-1:0] slc_byte;
    logic [IDX_W-1:0]  slc_idx;
    logic [BUS_W-1:0]  slc_word;

    assign nslc       = slices_per_byte(mode_q);
    assign mode16     = (mode_q == WSEL_16);
    assign last_slice = ({1'b0, idx_q} == (nslc - 4'd1));
    assign start_ok   = go_i && code_ok(width_sel_i);
    assign take       = (state_q == ST_FETCH) && in_valid_i;
    assign slc_byte   = (state_q == ST_SEND) ? hold_q : in_data_i;
    assign slc_idx    = (state_q == ST_SEND) ? idx_q  : '0;

    ptx_slicer slicer_i (
        .bin_i       (slc_byte),
        .mode_i      (mode_q),
        .idx_i       (slc_idx),
        .lsb_first_i (lsb_q),
        .slice_o     (slc_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = (len_i == '0) ? ST_DONE : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (in_valid_i) begin
                    if (nslc > 4'd1) begin
                        state_d = ST_SEND;
                    end else begin
                        state_d = (left_q == LEN_W'(1)) ? ST_DONE : ST_FETCH;
                    end
                end
            end
            ST_SEND: begin
                if (last_slice) begin
                    state_d = (left_q == '0) ? ST_DONE : ST_FETCH;
                end
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
        if (flush_i) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q   <= '0;
            idx_q    <= '0;
            hold_q   <= '0;
            low_q    <= '0;
            data_q   <= '0;
            word_q   <= 1'b0;
            mode_q   <= WSEL_8;
            lsb_q    <= 1'b0;
            strobe_q <= 1'b0;
            edge_q   <= 1'b0;
        end else if (flush_i) begin
            left_q <= '0;
            idx_q  <= '0;
            hold_q <= '0;
            low_q  <= '0;
            data_q <= '0;
            word_q <= 1'b0;
        end else begin
            word_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        left_q   <= len_i;
                        idx_q    <= '0;
                        mode_q   <= width_sel_i;
                        lsb_q    <= lsb_first_i;
                        strobe_q <= strobe_en_i;
                        edge_q   <= fall_edge_i;
                    end
                end
                ST_FETCH: begin
                    if (take) begin
                        left_q <= left_q - 1'b1;
                        if (mode16) begin
                            if (idx_q == '0 && left_q != LEN_W'(1)) begin
                                low_q <= in_data_i;
                                idx_q <= 3'd1;
                            end else begin
                                data_q <= (idx_q == '0) ? {8'h00, in_data_i}
                                                        : {in_data_i, low_q};
                                word_q <= 1'b1;
                                idx_q  <= '0;
                            end
                        end else begin
                            hold_q <= in_data_i;
                            data_q <= slc_word;
                            word_q <= 1'b1;
                            idx_q  <= (nslc > 4'd1) ? 3'd1 : 3'd0;
                        end
                    end
                end
                ST_SEND: begin
                    data_q <= slc_word;
                    word_q <= 1'b1;
                    idx_q  <= last_slice ? 3'd0 : idx_q + 3'd1;
                end
                ST_DONE: begin
                    idx_q <= '0;
                end
            endcase
        end
    end

    assign in_ready_o  = (state_q == ST_FETCH);
    assign bus_data_o  = data_q;
    assign bus_valid_o = word_q & strobe_q;
    assign done_o      = (state_q == ST_DONE);
    assign clk_en_o    = ~gate_en_i | word_q;
    assign clk_inv_o   = edge_q;

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !in_valid_i && !flush_i) |=> (!word_q && $stable(data_q)));

    // R7
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R9
    busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && go_i && !flush_i) |=>
            ($stable(mode_q) && $stable(lsb_q) && $stable(edge_q) && $stable(strobe_q)));

    // R6
    fetch_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> (left_q != '0));

    // R4
    send_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> ({1'b0, idx_q} < nslc));
endmodule

// File: rtl/ptx_unpack.sv
module ptx_unpack
    import ptx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              go,
    input  logic [2:0]        cfg_width_sel,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_lsb_first,
    input  logic              cfg_fall_edge,
    input  logic              cfg_strobe_en,
    input  logic              cfg_gate_en,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [15:0]       bus_data,
    output logic              bus_valid,
    output logic              done,
    output logic              out_clk_en,
    output logic              out_clk_inv
);
    ptx_ctrl #(.LEN_W(LEN_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .go_i        (go),
        .width_sel_i (cfg_width_sel),
        .len_i       (cfg_len),
        .lsb_first_i (cfg_lsb_first),
        .fall_edge_i (cfg_fall_edge),
        .strobe_en_i (cfg_strobe_en),
        .gate_en_i   (cfg_gate_en),
        .in_data_i   (in_data),
        .in_valid_i  (in_valid),
        .in_ready_o  (in_ready),
        .bus_data_o  (bus_data),
        .bus_valid_o (bus_valid),
        .done_o      (done),
        .clk_en_o    (out_clk_en),
        .clk_inv_o   (out_clk_inv)
    );
endmodule

// File: tb/ptx_unpack_tb.sv
module ptx_unpack_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        go = 1'b0;
    logic [2:0]  cfg_width_sel = 3'd1;
    logic [15:0] cfg_len = '0;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_fall_edge = 1'b0;
    logic        cfg_strobe_en = 1'b1;
    logic        cfg_gate_en = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] bus_data;
    logic        bus_valid;
    logic        done;
    logic        out_clk_en;
    logic        out_clk_inv;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    ptx_unpack dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .go(go),
        .cfg_width_sel(cfg_width_sel), .cfg_len(cfg_len),
        .cfg_lsb_first(cfg_lsb_first), .cfg_fall_edge(cfg_fall_edge),
        .cfg_strobe_en(cfg_strobe_en), .cfg_gate_en(cfg_gate_en),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .bus_data(bus_data), .bus_valid(bus_valid), .done(done),
        .out_clk_en(out_clk_en), .out_clk_inv(out_clk_inv)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((s * 13 + i * 37 + 5) & 255);
    endfunction

    task automatic run_xfer(input int code, input int len, input bit lsb, input bit stall,
                            input bit strobe, input bit gate, input bit edg,
                            input bit go_again, input int seed, input string req);
        int exp_q[$];
        int got_q[$];
        int sent = 0;
        int cyc = 0;
        bit seen_done = 0;
        bit stall_prev = 0;
        logic [15:0] prev_data;
        int mism = 0;
        int first_act = 0;
        int first_exp = 0;
        if (code == 0) begin
            for (int i = 0; i < len; i += 2) begin
                int hi = (i + 1 < len) ? int'(pat(seed, i + 1)) : 0;
                exp_q.push_back(hi * 256 + int'(pat(seed, i)));
            end
        end else begin
            int w = 8 >> (code - 1);
            int n = 8 / w;
            int mask = (1 << w) - 1;
            for (int i = 0; i < len; i++) begin
                for (int k = 0; k < n; k++) begin
                    int sh = lsb ? w * k : 8 - w * (k + 1);
                    exp_q.push_back((int'(pat(seed, i)) >> sh) & mask);
                end
            end
        end
        @(negedge clk);
        cfg_width_sel = 3'(code); cfg_len = 16'(len); cfg_lsb_first = lsb;
        cfg_strobe_en = strobe; cfg_gate_en = gate; cfg_fall_edge = edg; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cfg_fall_edge = ~edg;   // R13: change after capture
        prev_data = bus_data;
        while (!seen_done && cyc < 400) begin
            if (stall_prev) begin
                chk(!bus_valid && bus_data == prev_data, "R10 stall hold",
                    int'(bus_data), int'(prev_data));
            end
            if (gate) chk(out_clk_en == bus_valid, "R12 gated enable", out_clk_en, bus_valid);
            else      chk(out_clk_en == 1'b1, "R12 ungated enable", out_clk_en, 1);
            if (!strobe) chk(!bus_valid, "R11 strobe disabled", bus_valid, 0);
            if (bus_valid) got_q.push_back(int'(bus_data));
            if (done) begin
                seen_done = 1;
                chk(out_clk_inv == edg, "R13 edge latched", out_clk_inv, edg);
                if (strobe) begin
                    chk(got_q.size() == exp_q.size(), {req, " word count"},
                        got_q.size(), exp_q.size());
                    foreach (exp_q[j]) begin
                        if (j < got_q.size() && got_q[j] != exp_q[j]) begin
                            if (mism == 0) begin first_act = got_q[j]; first_exp = exp_q[j]; end
                            mism++;
                        end
                    end
                    chk(mism == 0, {req, " word stream"}, first_act, first_exp);
                    if (len > 0) chk(bus_valid, "R7 done with final word", bus_valid, 1);
                end else if (len > 0) begin
                    chk(int'(bus_data) == exp_q[exp_q.size()-1], "R11 data moves",
                        int'(bus_data), exp_q[exp_q.size()-1]);
                end
            end
            prev_data = bus_data;
            stall_prev = 0; in_valid = 1'b0; go = 1'b0;
            if (!seen_done && in_ready && sent < len) begin
                if (stall && (cyc % 3 == 1)) stall_prev = 1;
                else begin in_valid = 1'b1; in_data = pat(seed, sent); sent++; end
            end
            if (go_again && cyc == 2) begin go = 1'b1; cfg_len = 16'd7; end // R9
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0; go = 1'b0;
        chk(seen_done, {req, " done seen"}, seen_done, 1);
        chk(!done && !bus_valid && !in_ready, "R7 idle after done",
            {done, bus_valid, in_ready}, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        int seed = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_data == 16'h0 && !bus_valid && !done && !in_ready && !out_clk_inv,
            "R1 reset state", {bus_data, bus_valid, done, in_ready, out_clk_inv}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reserved codes
        for (int c = 5; c < 8; c++) begin
            cfg_width_sel = 3'(c); cfg_len = 16'd3; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            repeat (3) begin
                chk(!in_ready && !done, "R2 reserved code ignored", {in_ready, done}, 0);
                @(negedge clk);
            end
        end

        // R3 R4 R5 R6 R10 R12 sweep
        for (int code = 0; code < 5; code++)
            for (int lsb = 0; lsb < 2; lsb++)
                for (int li = 0; li < 4; li++)
                    for (int st = 0; st < 2; st++) begin
                        int lens[4] = '{1, 2, 3, 5};
                        string r = (code == 0) ? "R6" : (code == 1) ? "R3" :
                                   (lsb != 0) ? "R5" : "R4";
                        run_xfer(code, lens[li], lsb[0], st[0], 1'b1, st[0],
                                 li[0], 1'b0, seed, r);
                        seed++;
                    end

        // R8 zero length
        run_xfer(1, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, seed, "R8");
        // R9 go during active transfer
        run_xfer(2, 3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, seed + 1, "R9");
        // R11 strobe disabled
        run_xfer(1, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, seed + 2, "R11");

        // R14 flush mid-transfer
        @(negedge clk);
        cfg_width_sel = 3'd4; cfg_len = 16'd4; cfg_strobe_en = 1'b1; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        in_valid = 1'b1; in_data = 8'hA5;
        @(negedge clk);
        in_valid = 1'b0;
        chk(bus_valid && bus_data == 16'h1, "R14 pre-flush word", int'(bus_data), 1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(bus_data == 16'h0 && !bus_valid && !in_ready && !done, "R14 flush clears",
            {bus_data, bus_valid, in_ready, done}, 0);
        repeat (4) begin
            @(negedge clk);
            chk(!done && !in_ready, "R14 stays idle", {done, in_ready}, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule